// File: doc/BRIEF.md
# Shared System Bus Arbiter

This block shares one system bus among three processor masters and one DMA requester. Each master raises its own request and waits for its own grant before it drives address and data. The bus address space is 16 bits wide. Master 0 has a 16-bit data path and masters 1 and 2 have 8-bit data paths. The arbiter steers the granted master's address, write data and direction onto the bus. It also produces the byte-lane selects and returns read data to the granted master in that master's own width.

Arbitration takes place only while the bus is idle, which means no grant and no target acknowledge. A pending DMA request beats every processor request. Processor masters share the bus in round-robin order. A cycle ends in a fixed order: the target drops its acknowledge, then the master drops its request, and only then is the grant removed. If no target acknowledges within a bounded window, the arbiter aborts the cycle and flags a bus error to that master. A separate latch collects four interrupt request lines into sticky pending bits, and each bit is cleared by its own strobe.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, no grant is active, `bus_valid_o` is 0, `berr_o` is 0 and `irq_pend_o` is 0.
- R2: At most one grant (the three processor grants plus the DMA grant) is high in any cycle, and `bus_valid_o` is high exactly while a grant is high.
- R3: When the bus is idle and `ack_i` is low, a request is granted on the next clock edge. A grant never moves to another master while the current owner's cycle is in progress.
- R4: A DMA request that is pending at an arbitration point wins over all pending processor requests, whatever the round-robin position.
- R5: Processor priority rotates. After reset master 0 ranks highest. After master i completes or aborts a cycle, master i+1 (modulo 3) ranks highest, followed cyclically by the rest.
- R6: A grant stays high while `ack_i` is high. After `ack_i` falls, the grant stays high until the owner drops its request, and it falls on the clock edge that samples that request low.
- R7: If `ack_i` stays low for 16 consecutive granted cycles, the grant falls after the 16th cycle. In the same cycle, `berr_o[i]` of that master goes high for exactly one cycle.
- R8: While master 0 (16-bit) owns the bus, `bus_be_o` is 2'b11, its address and write data pass through unchanged, and all 16 bits of `bus_rdata_i` reach `m_rdata_o` of master 0.
- R9: While an 8-bit master owns the bus, `bus_be_o` is 2'b01 for an even address and 2'b10 for an odd address. Its low write byte appears on both lanes of `bus_wdata_o`. The selected read lane is returned in bits 7:0 of its `m_rdata_o`, and bits 15:8 read as zero.
- R10: A high `irq_i[k]` sets `irq_pend_o[k]` on the next edge. The bit then stays set until a cycle in which `irq_clr_i[k]` is high. A clear strobe on another bit has no effect on it, and a set and a clear in the same cycle leave the bit set.
- R11: While the DMA side owns the bus, `bus_be_o` is 2'b11, its address and data pass through, and `dma_rdata_o` returns `bus_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Processor bus requests |
| gnt_o | output | 3 | Processor bus grants |
| dma_req_i | input | 1 | DMA bus request |
| dma_gnt_o | output | 1 | DMA bus grant |
| m_addr_i | input | 48 | Processor addresses, 16 bits per master, master 0 lowest |
| m_wdata_i | input | 48 | Processor write data, 16 bits per master |
| m_we_i | input | 3 | Processor write enables |
| m_rdata_o | output | 48 | Read data per processor, in that master's width |
| dma_addr_i | input | 16 | DMA address |
| dma_wdata_i | input | 16 | DMA write data |
| dma_we_i | input | 1 | DMA write enable |
| dma_rdata_o | output | 16 | DMA read data |
| bus_valid_o | output | 1 | Bus owned by some master |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_we_o | output | 1 | Bus write enable |
| bus_be_o | output | 2 | Byte-lane selects, bit 1 is the upper lane |
| bus_rdata_i | input | 16 | Read data from the target |
| ack_i | input | 1 | Target acknowledge |
| berr_o | output | 3 | One-cycle bus error pulse per processor master |
| irq_i | input | 4 | Interrupt request lines |
| irq_clr_i | input | 4 | Per-bit pending clear strobes |
| irq_pend_o | output | 4 | Pending interrupt bits |

## Verification
Assertions check on every cycle that grants stay one-hot and that a grant holds through acknowledge and through the release phase. They also check that an idle bus with a DMA request grants DMA next, that a bus error follows a grant, that the ack wait stays within its window, that an owned bus always drives a byte lane, and that pending interrupt bits are sticky. Only the bench scenarios can show the rotating order across several completions, the exact 16-cycle abort length, and the lane steering and read-data placement for odd and even narrow accesses. The same holds for DMA winning against a round-robin position that favours a processor.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_REL  = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan from the farthest offset down so the nearest requester wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(ptr_i) + k) % N;
      if (req_i[j]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/arb_width_steer.sv
module arb_width_steer #(
  parameter int          N_CPU     = 3,
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter int          OWN_W     = 2,
  parameter logic [31:0] WIDE_MASK = 32'h1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    owner_valid_i,
  input  logic [OWN_W-1:0]        owner_i,
  input  logic [N_CPU*ADDR_W-1:0] m_addr_i,
  input  logic [N_CPU*DATA_W-1:0] m_wdata_i,
  input  logic [N_CPU-1:0]        m_we_i,
  output logic [N_CPU*DATA_W-1:0] m_rdata_o,
  input  logic [ADDR_W-1:0]       dma_addr_i,
  input  logic [DATA_W-1:0]       dma_wdata_i,
  input  logic                    dma_we_i,
  output logic [DATA_W-1:0]       dma_rdata_o,
  input  logic [DATA_W-1:0]       bus_rdata_i,
  output logic                    bus_valid_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic [DATA_W-1:0]       bus_wdata_o,
  output logic                    bus_we_o,
  output logic [1:0]              bus_be_o
);
  localparam int HALF = DATA_W / 2;
  localparam logic [OWN_W-1:0] DMA_ID = OWN_W'(N_CPU);

  logic [1:0]        m_be  [N_CPU];
  logic [DATA_W-1:0] m_bwd [N_CPU];

  for (genvar i = 0; i < N_CPU; i++) begin : g_lane
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] wd;
    assign a  = m_addr_i[i*ADDR_W +: ADDR_W];
    assign wd = m_wdata_i[i*DATA_W +: DATA_W];
    if (WIDE_MASK[i]) begin : g_wide
      assign m_be[i]  = 2'b11;
      assign m_bwd[i] = wd;
      assign m_rdata_o[i*DATA_W +: DATA_W] = bus_rdata_i;
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^wd[DATA_W-1:HALF];
      assign m_be[i]  = a[0] ? 2'b10 : 2'b01;
      assign m_bwd[i] = {wd[HALF-1:0], wd[HALF-1:0]};
      assign m_rdata_o[i*DATA_W +: DATA_W] =
        {{HALF{1'b0}}, (a[0] ? bus_rdata_i[DATA_W-1:HALF] : bus_rdata_i[HALF-1:0])};
    end
  end

  assign dma_rdata_o = bus_rdata_i;
  assign bus_valid_o = owner_valid_i;

  always_comb begin
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    bus_we_o    = 1'b0;
    bus_be_o    = 2'b00;
    if (owner_valid_i) begin
      if (owner_i == DMA_ID) begin
        bus_addr_o  = dma_addr_i;
        bus_wdata_o = dma_wdata_i;
        bus_we_o    = dma_we_i;
        bus_be_o    = 2'b11;
      end else begin
        for (int i = 0; i < N_CPU; i++) begin
          if (owner_i == OWN_W'(i)) begin
            bus_addr_o  = m_addr_i[i*ADDR_W +: ADDR_W];
            bus_wdata_o = m_bwd[i];
            bus_we_o    = m_we_i[i];
            bus_be_o    = m_be[i];
          end
        end
      end
    end
  end

  p_lane_driven_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (bus_be_o != 2'b00));
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_o |-> (bus_be_o == 2'b00 && !bus_we_o));
endmodule

// File: rtl/arb_irq_latch.sv
module arb_irq_latch #(
  parameter int N_IRQ = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [N_IRQ-1:0] pend_o
);
  logic [N_IRQ-1:0] pend_q;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | irq_i;
  end

  assign pend_o = pend_q;

  for (genvar k = 0; k < N_IRQ; k++) begin : g_chk
    p_pend_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[k] && !clr_i[k]) |=> pend_q[k]);
    p_pend_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[k] |=> pend_q[k]);
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int          N_CPU       = 3,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 16,
  parameter int          N_IRQ       = 4,
  parameter int          ACK_TIMEOUT = 16,
  parameter logic [31:0] WIDE_MASK   = 32'h1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_CPU-1:0]        req_i,
  output logic [N_CPU-1:0]        gnt_o,
  input  logic                    dma_req_i,
  output logic                    dma_gnt_o,
  input  logic [N_CPU*ADDR_W-1:0] m_addr_i,
  input  logic [N_CPU*DATA_W-1:0] m_wdata_i,
  input  logic [N_CPU-1:0]        m_we_i,
  output logic [N_CPU*DATA_W-1:0] m_rdata_o,
  input  logic [ADDR_W-1:0]       dma_addr_i,
  input  logic [DATA_W-1:0]       dma_wdata_i,
  input  logic                    dma_we_i,
  output logic [DATA_W-1:0]       dma_rdata_o,
  output logic                    bus_valid_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic [DATA_W-1:0]       bus_wdata_o,
  output logic                    bus_we_o,
  output logic [1:0]              bus_be_o,
  input  logic [DATA_W-1:0]       bus_rdata_i,
  input  logic                    ack_i,
  output logic [N_CPU-1:0]        berr_o,
  input  logic [N_IRQ-1:0]        irq_i,
  input  logic [N_IRQ-1:0]        irq_clr_i,
  output logic [N_IRQ-1:0]        irq_pend_o
);
  localparam int OWN_W = $clog2(N_CPU + 1);
  localparam int TMR_W = $clog2(ACK_TIMEOUT + 1);
  localparam logic [OWN_W-1:0] DMA_ID   = OWN_W'(N_CPU);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ACK_TIMEOUT - 1);

  arb_state_e       state_q, state_d;
  logic [OWN_W-1:0] owner_q, owner_d, ptr_q, ptr_d, next_ptr, pick_idx;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [N_CPU-1:0] berr_q, berr_d;
  logic             pick_valid, busy, owner_is_cpu, owner_req;

  arb_rr_pick #(.N(N_CPU), .IDX_W(OWN_W)) u_pick (
    .req_i   (req_i),
    .ptr_i   (ptr_q),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  assign busy         = (state_q != ST_IDLE);
  assign owner_is_cpu = (owner_q != DMA_ID);
  assign next_ptr     = (owner_q == OWN_W'(N_CPU - 1)) ? '0 : owner_q + 1'b1;

  always_comb begin
    owner_req = dma_req_i;
    for (int i = 0; i < N_CPU; i++)
      if (owner_q == OWN_W'(i)) owner_req = req_i[i];
  end

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    ptr_d   = ptr_q;
    tmr_d   = tmr_q;
    berr_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_d = '0;
        if (!ack_i) begin
          if (dma_req_i) begin
            state_d = ST_WAIT;
            owner_d = DMA_ID;
          end else if (pick_valid) begin
            state_d = ST_WAIT;
            owner_d = pick_idx;
          end
        end
      end
      ST_WAIT: begin
        if (ack_i) begin
          state_d = ST_ACK;
        end else if (tmr_q == TMR_LAST) begin
          state_d = ST_IDLE;
          if (owner_is_cpu) begin
            ptr_d = next_ptr;
            for (int i = 0; i < N_CPU; i++)
              if (owner_q == OWN_W'(i)) berr_d[i] = 1'b1;
          end
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_ACK: if (!ack_i) state_d = ST_REL;
      ST_REL: begin
        if (!owner_req) begin
          state_d = ST_IDLE;
          if (owner_is_cpu) ptr_d = next_ptr;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      ptr_q   <= '0;
      tmr_q   <= '0;
      berr_q  <= '0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
      ptr_q   <= ptr_d;
      tmr_q   <= tmr_d;
      berr_q  <= berr_d;
    end
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_gnt
    assign gnt_o[i] = busy && (owner_q == OWN_W'(i));
  end
  assign dma_gnt_o = busy && (owner_q == DMA_ID);
  assign berr_o    = berr_q;

  arb_width_steer #(
    .N_CPU(N_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OWN_W(OWN_W), .WIDE_MASK(WIDE_MASK)
  ) u_steer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .owner_valid_i (busy),
    .owner_i       (owner_q),
    .m_addr_i      (m_addr_i),
    .m_wdata_i     (m_wdata_i),
    .m_we_i        (m_we_i),
    .m_rdata_o     (m_rdata_o),
    .dma_addr_i    (dma_addr_i),
    .dma_wdata_i   (dma_wdata_i),
    .dma_we_i      (dma_we_i),
    .dma_rdata_o   (dma_rdata_o),
    .bus_rdata_i   (bus_rdata_i),
    .bus_valid_o   (bus_valid_o),
    .bus_addr_o    (bus_addr_o),
    .bus_wdata_o   (bus_wdata_o),
    .bus_we_o      (bus_we_o),
    .bus_be_o      (bus_be_o)
  );

  arb_irq_latch #(.N_IRQ(N_IRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .clr_i  (irq_clr_i),
    .pend_o (irq_pend_o)
  );

  p_onehot_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_gnt_o, gnt_o}));
  p_valid_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o == (|{dma_gnt_o, gnt_o}));
  p_hold_in_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|{dma_gnt_o, gnt_o}) && ack_i) |=> ({dma_gnt_o, gnt_o} == $past({dma_gnt_o, gnt_o})));
  p_hold_until_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REL && owner_req) |=> ({dma_gnt_o, gnt_o} == $past({dma_gnt_o, gnt_o})));
  p_dma_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !ack_i && dma_req_i) |=> dma_gnt_o);
  p_berr_after_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|berr_o) |-> ($past(|gnt_o) && !(|gnt_o)));
  p_wait_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (tmr_q <= TMR_LAST));
endmodule

// File: tb/tb_bus_arbiter.sv
module tb_bus_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req = '0;
  logic [2:0]  gnt;
  logic        dma_req = 1'b0, dma_gnt;
  logic [15:0] m_addr [3];
  logic [15:0] m_wd [3];
  logic [2:0]  m_we = '0;
  logic [47:0] m_rdata;
  logic [15:0] dma_addr = '0, dma_wd = '0, dma_rdata;
  logic        dma_we = 1'b0;
  logic        bus_valid, bus_we;
  logic [15:0] bus_addr, bus_wdata;
  logic [1:0]  bus_be;
  logic [15:0] bus_rdata = '0;
  logic        ack = 1'b0;
  logic [2:0]  berr;
  logic [3:0]  irq = '0, irq_clr = '0, irq_pend;

  int n_chk = 0, n_fail = 0;

  typedef struct packed {
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [1:0]  be;
    logic        we;
    logic [3:0]  own;
  } item_t;
  item_t exp_q[$];
  bit mon_seen = 1'b0;

  always #2 clk = ~clk;

  bus_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(gnt),
    .dma_req_i(dma_req), .dma_gnt_o(dma_gnt),
    .m_addr_i({m_addr[2], m_addr[1], m_addr[0]}),
    .m_wdata_i({m_wd[2], m_wd[1], m_wd[0]}),
    .m_we_i(m_we), .m_rdata_o(m_rdata),
    .dma_addr_i(dma_addr), .dma_wdata_i(dma_wd), .dma_we_i(dma_we), .dma_rdata_o(dma_rdata),
    .bus_valid_o(bus_valid), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_we_o(bus_we), .bus_be_o(bus_be), .bus_rdata_i(bus_rdata), .ack_i(ack),
    .berr_o(berr), .irq_i(irq), .irq_clr_i(irq_clr), .irq_pend_o(irq_pend)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [3:0] gall();
    return {dma_gnt, gnt};
  endfunction

  // expected bus image for a given owner (3 = DMA)
  function automatic item_t exp_item(input int idx);
    item_t it;
    if (idx == 3) begin
      it = '{addr: dma_addr, wdata: dma_wd, be: 2'b11, we: dma_we, own: 4'b1000};
    end else if (idx == 0) begin
      it = '{addr: m_addr[0], wdata: m_wd[0], be: 2'b11, we: m_we[0], own: 4'b0001};
    end else begin
      it.addr  = m_addr[idx];
      it.wdata = {m_wd[idx][7:0], m_wd[idx][7:0]};
      it.be    = m_addr[idx][0] ? 2'b10 : 2'b01;
      it.we    = m_we[idx];
      it.own   = 4'(1 << idx);
    end
    return it;
  endfunction

  // monitor: first acknowledged cycle of every transfer is compared with the scoreboard
  always @(negedge clk) begin
    if (rst_n && ack && bus_valid && !mon_seen) begin
      mon_seen = 1'b1;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected bus cycle", 64'(gall()), 64'h0);
      end else begin
        item_t e;
        item_t a;
        e = exp_q.pop_front();
        a = '{addr: bus_addr, wdata: bus_wdata, be: bus_be, we: bus_we, own: gall()};
        check(a == e, (e.own[0] ? "R8" : (e.own[3] ? "R11" : "R9")),
              "bus image", 64'(a), 64'(e));
      end
    end
    if (!ack) mon_seen = 1'b0;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_gnt(input int idx, input string rq);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (gall() != 4'b0) break;
    end
    check(gall() == 4'(1 << idx), rq, "granted owner", 64'(gall()), 64'(1 << idx));
  endtask

  task automatic ack_cycle(input int idx, input logic [15:0] rd, input logic [15:0] exp_rd,
                           input string rq);
    exp_q.push_back(exp_item(idx));
    step();
    ack = 1'b1;
    bus_rdata = rd;
    for (int k = 0; k < 2; k++) begin
      logic [15:0] got;
      @(negedge clk);
      got = (idx == 3) ? dma_rdata : m_rdata[idx*16 +: 16];
      check(got == exp_rd, rq, "read data", 64'(got), 64'(exp_rd));
      check(gall() == 4'(1 << idx), "R6", "grant held in ack", 64'(gall()), 64'(1 << idx));
    end
    step();
    ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(gall() == 4'(1 << idx), "R6", "grant held after ack drop", 64'(gall()), 64'(1 << idx));
  endtask

  task automatic release_bus(input int idx);
    step();
    if (idx == 3) dma_req = 1'b0; else req[idx] = 1'b0;
    @(negedge clk);
    check(gall() == 4'(1 << idx), "R6", "grant before req sampled", 64'(gall()), 64'(1 << idx));
    @(negedge clk);
    check(gall() == 4'b0, "R6", "grant dropped after req", 64'(gall()), 64'h0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_addr[i] = '0;
      m_wd[i]   = '0;
    end
    repeat (3) @(negedge clk);
    check(gall() == 4'b0 && !bus_valid, "R1", "grants after reset", 64'(gall()), 64'h0);
    check(irq_pend == 4'b0 && berr == 3'b0, "R1", "pend/berr after reset",
          64'({irq_pend, berr}), 64'h0);
    step();
    rst_n = 1'b1;
    step();

    // R3, R8: wide master, grant one edge after the request
    m_addr[0] = 16'h1234; m_wd[0] = 16'hABCD; m_we[0] = 1'b1;
    req[0] = 1'b1;
    @(negedge clk);
    check(gall() == 4'b0, "R3", "no grant before edge", 64'(gall()), 64'h0);
    @(negedge clk);
    check(gall() == 4'b0001 && bus_valid, "R3", "grant after one edge", 64'(gall()), 64'h1);
    ack_cycle(0, 16'h5A6B, 16'h5A6B, "R8");
    release_bus(0);

    // R9: narrow master, odd address selects the upper lane
    m_addr[1] = 16'h2001; m_wd[1] = 16'h00C3; m_we[1] = 1'b1;
    step(); req[1] = 1'b1;
    wait_gnt(1, "R9");
    ack_cycle(1, 16'h9F11, 16'h009F, "R9");
    release_bus(1);

    // R9: narrow master, even address, upper write byte ignored
    m_addr[2] = 16'h3000; m_wd[2] = 16'hFF7E; m_we[2] = 1'b0;
    step(); req[2] = 1'b1;
    wait_gnt(2, "R9");
    ack_cycle(2, 16'h9F11, 16'h0011, "R9");
    release_bus(2);

    // R5: rotation, pointer back at master 0
    step(); req = 3'b111;
    wait_gnt(0, "R5");
    ack_cycle(0, 16'h0101, 16'h0101, "R8");
    release_bus(0);
    wait_gnt(1, "R5");
    ack_cycle(1, 16'h0202, 16'h0002, "R9");
    req[0] = 1'b1;
    release_bus(1);
    wait_gnt(2, "R5");
    ack_cycle(2, 16'h0303, 16'h0003, "R9");
    release_bus(2);
    wait_gnt(0, "R5");
    ack_cycle(0, 16'h0404, 16'h0404, "R8");
    release_bus(0);

    // R4, R11: DMA beats a simultaneous processor request
    dma_addr = 16'h8000; dma_wd = 16'h1357; dma_we = 1'b1;
    step(); req[1] = 1'b1; dma_req = 1'b1;
    wait_gnt(3, "R4");
    ack_cycle(3, 16'hC0DE, 16'hC0DE, "R11");
    release_bus(3);
    wait_gnt(1, "R4");
    // R3: DMA request mid-cycle does not steal the bus
    step(); dma_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(gall() == 4'b0010, "R3", "no mid-cycle switch", 64'(gall()), 64'h2);
    end
    ack_cycle(1, 16'h1111, 16'h0011, "R9");
    req[2] = 1'b1;
    release_bus(1);
    wait_gnt(3, "R4");
    ack_cycle(3, 16'h2222, 16'h2222, "R11");
    release_bus(3);
    wait_gnt(2, "R5");
    ack_cycle(2, 16'h3333, 16'h0033, "R9");
    release_bus(2);

    // R7: no acknowledge, abort after 16 granted cycles
    begin
      int n;
      step(); req[2] = 1'b1;
      wait_gnt(2, "R7");
      step(); req[2] = 1'b0;
      n = 1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (gnt[2]) n++; else break;
      end
      check(n == 16, "R7", "granted cycles before abort", 64'(n), 64'd16);
      check(berr == 3'b100 && gall() == 4'b0, "R7", "error pulse", 64'(berr), 64'h4);
      @(negedge clk);
      check(berr == 3'b000, "R7", "error pulse one cycle", 64'(berr), 64'h0);
    end

    // R10: interrupt pending latch
    step(); irq = 4'b0010;
    step(); irq = 4'b0000;
    @(negedge clk);
    check(irq_pend == 4'b0010, "R10", "set", 64'(irq_pend), 64'h2);
    repeat (3) @(negedge clk);
    check(irq_pend == 4'b0010, "R10", "held", 64'(irq_pend), 64'h2);
    step(); irq_clr = 4'b0001;
    step(); irq_clr = 4'b0000;
    @(negedge clk);
    check(irq_pend == 4'b0010, "R10", "other clear ignored", 64'(irq_pend), 64'h2);
    step(); irq_clr = 4'b0010;
    step(); irq_clr = 4'b0000;
    @(negedge clk);
    check(irq_pend == 4'b0000, "R10", "cleared", 64'(irq_pend), 64'h0);
    step(); irq = 4'b1000; irq_clr = 4'b1000;
    step(); irq = 4'b0000; irq_clr = 4'b0000;
    @(negedge clk);
    check(irq_pend == 4'b1000, "R10", "set wins over clear", 64'(irq_pend), 64'h8);
    step(); irq_clr = 4'b1000;
    step(); irq_clr = 4'b0000;
    @(negedge clk);
    check(irq_pend == 4'b0000, "R10", "clear after set", 64'(irq_pend), 64'h0);

    check(exp_q.size() == 0, "R2", "scoreboard drained", 64'(exp_q.size()), 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule